// File: doc/BRIEF.md
# Floating-Point Significand Alignment Unit

This block prepares two floating-point operands for an adder by bringing them to a common exponent. Each operand arrives as an exponent and a significand. The unit subtracts the exponents to find the operand with the smaller exponent. It then shifts that operand's significand right by the size of the gap. The other significand passes through untouched.

The right shift is built as a chain of 2:1 multiplexer stages, one stage for each bit of the shift amount. Each stage moves the word by a fixed power of two, and the largest step comes first. The whole alignment therefore settles within a single clock period, whatever the gap. Bits that fall off the low end are collapsed into a sticky bit for a later rounding step.

A valid strobe marks a new operand pair. The aligned results, the common exponent and a swap flag are registered and appear with a matching valid pulse one cycle later. Signs, the add or subtract itself, normalization, rounding and special values are handled outside this unit.

Top module: `fp_align_unit`

## Requirements
- R1: `common_exp` equals the larger of `a_exp` and `b_exp`.
- R2: `big_sig` is the unchanged significand of the operand with the larger exponent. On equal exponents it is `a_sig`.
- R3: `aligned_sig` is the other operand's significand shifted right by the absolute exponent difference, with zeros filling from the most significant side and no rotation.
- R4: `swapped` is 1 exactly when `b_exp` is strictly greater than `a_exp`, which means operand A was the one shifted.
- R5: When the exponents are equal, `aligned_sig` equals `b_sig`, `swapped` is 0 and `sticky` is 0.
- R6: When the exponent difference is at least SIG_W, `aligned_sig` is all zeros and `sticky` is the OR of every bit of the shifted significand.
- R7: `sticky` is the OR of all bits shifted out below the least significant position.
- R8: `out_valid` is high exactly one cycle after each cycle with `in_valid` high. The result outputs change only on such a cycle and hold their value otherwise.
- R9: While `rst_n` is low at a clock edge, `out_valid` and every result output are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: capture a new operand pair |
| a_exp | input | EXP_W | Exponent of operand A |
| a_sig | input | SIG_W | Significand of operand A |
| b_exp | input | EXP_W | Exponent of operand B |
| b_sig | input | SIG_W | Significand of operand B |
| out_valid | output | 1 | Results valid, one cycle after the strobe |
| big_sig | output | SIG_W | Significand of the larger-exponent operand |
| aligned_sig | output | SIG_W | Right-shifted significand of the smaller-exponent operand |
| common_exp | output | EXP_W | Larger exponent, shared by both results |
| swapped | output | 1 | 1 when operand A was shifted |
| sticky | output | 1 | OR of the bits shifted out |

## Verification
On every cycle, the assertions check the one-cycle valid timing, that results hold when no strobe arrives, the choice of the larger exponent and its unshifted significand, the swap flag, the equal-exponent case and the zero result for an oversized gap. Inside the datapath they also check the zero-shift identity and the exponent arithmetic. The exact shifted value and the sticky bit for partial shifts can only be shown by the bench. It does this with a hand-computed vector table that covers gaps of 0, 1, width-1, width and the maximum, followed by random operand pairs that are compared against a shift-operator model.

// File: rtl/fpa_pkg.sv
`timescale 1ns/1ps
// fpa_pkg: shared helpers for the significand alignment unit.
// Assumes callers pass a positive significand width.
package fpa_pkg;
    // Number of power-of-two stages needed to cover shifts below width w.
    function automatic int stage_bits(input int w);
        return (w <= 2) ? 1 : $clog2(w);
    endfunction
endpackage

// File: rtl/fpa_exp_compare.sv
`timescale 1ns/1ps
// fpa_exp_compare: subtracts the two exponents, picks the operand with the
// larger exponent (ties go to operand A) and routes the significands.
// Purely combinational. Assumes unsigned biased exponents.
module fpa_exp_compare #(
    parameter int EXP_W = 8,
    parameter int SIG_W = 24
) (
    input  logic [EXP_W-1:0] a_exp_i,
    input  logic [SIG_W-1:0] a_sig_i,
    input  logic [EXP_W-1:0] b_exp_i,
    input  logic [SIG_W-1:0] b_sig_i,
    output logic             swap_o,
    output logic [EXP_W-1:0] big_exp_o,
    output logic [EXP_W-1:0] gap_o,
    output logic [SIG_W-1:0] big_sig_o,
    output logic [SIG_W-1:0] small_sig_o
);
    logic [EXP_W:0] a_minus_b;

    // Borrow of A-B tells whether B has the strictly larger exponent.
    always_comb begin
        a_minus_b = {1'b0, a_exp_i} - {1'b0, b_exp_i};
        swap_o    = a_minus_b[EXP_W];
    end

    // Route exponent, gap magnitude and significands by the swap decision.
    always_comb begin
        if (swap_o) begin
            big_exp_o   = b_exp_i;
            gap_o       = b_exp_i - a_exp_i;
            big_sig_o   = b_sig_i;
            small_sig_o = a_sig_i;
        end else begin
            big_exp_o   = a_exp_i;
            gap_o       = a_minus_b[EXP_W-1:0];
            big_sig_o   = a_sig_i;
            small_sig_o = b_sig_i;
        end
    end

    // The gap subtracted from the chosen exponent gives back the other one.
    always_comb begin
        if (!swap_o) AST_GAP_CONSISTENT: assert (big_exp_o - gap_o == b_exp_i); // R1
        else         AST_GAP_CONSISTENT_SW: assert (big_exp_o - gap_o == a_exp_i); // R1
    end
endmodule

// File: rtl/fpa_rshift.sv
`timescale 1ns/1ps
// fpa_rshift: logical right shifter built from a cascade of 2:1 mux stages,
// the largest power-of-two step first. Collects a sticky bit from each stage
// and saturates to zero when the amount reaches SIG_W.
// Assumes AMT_W >= stage_bits(SIG_W). Purely combinational.
module fpa_rshift #(
    parameter int SIG_W = 24,
    parameter int AMT_W = 8
) (
    input  logic [SIG_W-1:0] sig_i,
    input  logic [AMT_W-1:0] amt_i,
    output logic [SIG_W-1:0] sig_o,
    output logic             sticky_o
);
    localparam int             SH_W = fpa_pkg::stage_bits(SIG_W);
    localparam logic [AMT_W:0] LIM  = (AMT_W+1)'(SIG_W);

    logic [SIG_W-1:0] lvl [SH_W+1];
    logic [SH_W-1:0]  lost;
    logic             far;

    assign lvl[0] = sig_i;

    // One mux stage per amount bit, most significant bit first.
    for (genvar g = 0; g < SH_W; g++) begin : g_stage
        localparam int K    = SH_W - 1 - g;
        localparam int STEP = 1 << K;
        assign lvl[g+1] = amt_i[K] ? (lvl[g] >> STEP) : lvl[g];
        assign lost[g]  = amt_i[K] & (|lvl[g][STEP-1:0]);
    end

    // Oversized amounts flush the word and fold all its bits into sticky.
    always_comb begin
        far      = {1'b0, amt_i} >= LIM;
        sig_o    = far ? '0 : lvl[SH_W];
        sticky_o = far ? (|sig_i) : (|lost);
    end

    // A zero amount must leave the word intact with nothing lost.
    always_comb begin
        if (amt_i == '0) AST_ZERO_SHIFT_IDENT: assert (sig_o == sig_i && !sticky_o); // R5
    end
endmodule

// File: rtl/fp_align_unit.sv
`timescale 1ns/1ps
// fp_align_unit: aligns two floating-point significands to the larger
// exponent in one cycle. Inputs are taken on in_valid, and results are
// registered with out_valid one cycle later. Ties keep operand A as the larger.
// Assumes EXP_W >= clog2(SIG_W) and unsigned biased exponents.
module fp_align_unit #(
    parameter int EXP_W = 8,
    parameter int SIG_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [EXP_W-1:0] a_exp,
    input  logic [SIG_W-1:0] a_sig,
    input  logic [EXP_W-1:0] b_exp,
    input  logic [SIG_W-1:0] b_sig,
    output logic             out_valid,
    output logic [SIG_W-1:0] big_sig,
    output logic [SIG_W-1:0] aligned_sig,
    output logic [EXP_W-1:0] common_exp,
    output logic             swapped,
    output logic             sticky
);
    localparam logic [EXP_W:0] SIG_LIM = (EXP_W+1)'(SIG_W);

    logic             swap_c;
    logic [EXP_W-1:0] exp_c;
    logic [EXP_W-1:0] gap_c;
    logic [SIG_W-1:0] big_c;
    logic [SIG_W-1:0] small_c;
    logic [SIG_W-1:0] shifted_c;
    logic             sticky_c;

    fpa_exp_compare #(.EXP_W(EXP_W), .SIG_W(SIG_W)) i_cmp (
        .a_exp_i    (a_exp),
        .a_sig_i    (a_sig),
        .b_exp_i    (b_exp),
        .b_sig_i    (b_sig),
        .swap_o     (swap_c),
        .big_exp_o  (exp_c),
        .gap_o      (gap_c),
        .big_sig_o  (big_c),
        .small_sig_o(small_c)
    );

    fpa_rshift #(.SIG_W(SIG_W), .AMT_W(EXP_W)) i_shf (
        .sig_i   (small_c),
        .amt_i   (gap_c),
        .sig_o   (shifted_c),
        .sticky_o(sticky_c)
    );

    // Register the aligned pair on a strobe; the valid output follows the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            big_sig     <= '0;
            aligned_sig <= '0;
            common_exp  <= '0;
            swapped     <= 1'b0;
            sticky      <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                big_sig     <= big_c;
                aligned_sig <= shifted_c;
                common_exp  <= exp_c;
                swapped     <= swap_c;
                sticky      <= sticky_c;
            end
        end
    end

    // Port-level view of the gap, used only by the checks below.
    logic [EXP_W-1:0] chk_gap;
    logic             chk_far;
    always_comb begin
        chk_gap = (a_exp >= b_exp) ? (a_exp - b_exp) : (b_exp - a_exp);
        chk_far = {1'b0, chk_gap} >= SIG_LIM;
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R8
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> !out_valid); // R8
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !in_valid |=> $stable(aligned_sig) && $stable(common_exp) && $stable(big_sig)); // R8
    AST_EXP_IS_MAX: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> common_exp == (($past(a_exp) >= $past(b_exp)) ? $past(a_exp) : $past(b_exp))); // R1
    AST_BIG_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> big_sig == (swapped ? $past(b_sig) : $past(a_sig))); // R2
    AST_SWAP_FLAG: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> swapped == ($past(b_exp) > $past(a_exp))); // R4
    AST_TIE_NO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n) in_valid && (a_exp == b_exp) |=> !swapped && !sticky && aligned_sig == $past(b_sig)); // R5
    AST_FAR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n) in_valid && chk_far |=> aligned_sig == '0); // R6
endmodule

// File: tb/test_fp_align_unit.sv
`timescale 1ns/1ps
module test_fp_align_unit;
    localparam int EW = 6;
    localparam int SW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [EW-1:0] a_exp = '0, b_exp = '0;
    logic [SW-1:0] a_sig = '0, b_sig = '0;
    logic          out_valid, swapped, sticky;
    logic [SW-1:0] big_sig, aligned_sig;
    logic [EW-1:0] common_exp;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    fp_align_unit #(.EXP_W(EW), .SIG_W(SW)) i_fp_align_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_exp(a_exp), .a_sig(a_sig), .b_exp(b_exp), .b_sig(b_sig),
        .out_valid(out_valid), .big_sig(big_sig), .aligned_sig(aligned_sig),
        .common_exp(common_exp), .swapped(swapped), .sticky(sticky)
    );

    // {a_exp, a_sig, b_exp, b_sig, exp, big, aligned, swapped, sticky}
    localparam logic [51:0] VEC [10] = '{
        {6'd10, 8'hB5, 6'd10, 8'h3C, 6'd10, 8'hB5, 8'h3C, 1'b0, 1'b0},
        {6'd12, 8'h80, 6'd11, 8'hFF, 6'd12, 8'h80, 8'h7F, 1'b0, 1'b1},
        {6'd5,  8'h81, 6'd9,  8'hC0, 6'd9,  8'hC0, 8'h08, 1'b1, 1'b1},
        {6'd20, 8'h01, 6'd13, 8'h80, 6'd20, 8'h01, 8'h01, 1'b0, 1'b0},
        {6'd20, 8'hFF, 6'd12, 8'h80, 6'd20, 8'hFF, 8'h00, 1'b0, 1'b1},
        {6'd0,  8'h40, 6'd63, 8'h12, 6'd63, 8'h12, 8'h00, 1'b1, 1'b1},
        {6'd30, 8'hAA, 6'd28, 8'h0C, 6'd30, 8'hAA, 8'h03, 1'b0, 1'b0},
        {6'd3,  8'h00, 6'd40, 8'h55, 6'd40, 8'h55, 8'h00, 1'b1, 1'b0},
        {6'd17, 8'h9D, 6'd19, 8'h77, 6'd19, 8'h77, 8'h27, 1'b1, 1'b1},
        {6'd50, 8'h12, 6'd44, 8'hF0, 6'd50, 8'h12, 8'h03, 1'b0, 1'b1}
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [EW-1:0] ae, input logic [SW-1:0] as_, input logic [EW-1:0] be, input logic [SW-1:0] bs);
        @(negedge clk);
        a_exp = ae; a_sig = as_; b_exp = be; b_sig = bs; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic check_all(input string req, input logic [EW-1:0] e, input logic [SW-1:0] bg,
                             input logic [SW-1:0] al, input logic sw, input logic st);
        chk("R8", {req, " out_valid"}, 32'(out_valid), 32'd1);
        chk("R1", {req, " common_exp"}, 32'(common_exp), 32'(e));
        chk("R2", {req, " big_sig"}, 32'(big_sig), 32'(bg));
        chk("R3", {req, " aligned_sig"}, 32'(aligned_sig), 32'(al));
        chk("R4", {req, " swapped"}, 32'(swapped), 32'(sw));
        chk("R7", {req, " sticky"}, 32'(sticky), 32'(st));
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        // R9: reset clears everything even while a strobe is present
        a_exp = 6'd33; a_sig = 8'hEE; b_exp = 6'd2; b_sig = 8'h77; in_valid = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9", "reset out_valid", 32'(out_valid), 0);
        chk("R9", "reset big_sig", 32'(big_sig), 0);
        chk("R9", "reset aligned_sig", 32'(aligned_sig), 0);
        chk("R9", "reset common_exp", 32'(common_exp), 0);
        chk("R9", "reset swapped", 32'(swapped), 0);
        chk("R9", "reset sticky", 32'(sticky), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;

        // Vector table: ties (R5), width-1, width (R6) and maximum gaps
        for (int i = 0; i < 10; i++) begin
            drive(VEC[i][51:46], VEC[i][45:38], VEC[i][37:32], VEC[i][31:24]);
            check_all(i == 0 ? "R5 tie" : (i == 4 || i == 5) ? "R6 far" : "R3 table",
                      VEC[i][23:18], VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
        end

        // R8: no strobe, new inputs, outputs must hold the last result
        @(negedge clk);
        chk("R8", "idle out_valid", 32'(out_valid), 0);
        a_exp = 6'd1; a_sig = 8'h11; b_exp = 6'd60; b_sig = 8'h22;
        @(negedge clk);
        chk("R8", "hold common_exp", 32'(common_exp), 32'd50);
        chk("R8", "hold aligned_sig", 32'(aligned_sig), 32'h03);
        chk("R8", "hold big_sig", 32'(big_sig), 32'h12);

        // R6: gap above width with only the lowest bit set still gives sticky
        drive(6'd9, 8'h01, 6'd0, 8'h01);
        chk("R6", "far sticky", 32'(sticky), 1);
        chk("R6", "far aligned", 32'(aligned_sig), 0);

        // Random pairs against a shift-operator model (R1..R7)
        for (int n = 0; n < 300; n++) begin
            logic [EW-1:0] ae, be, e;
            logic [SW-1:0] as_, bs, bg, sm, al;
            logic          sw, st;
            int            gap;
            ae = EW'($urandom); as_ = SW'($urandom);
            bs = SW'($urandom);
            case (n % 4)
                0: be = ae;
                1: be = ae + EW'($urandom_range(0, 9));
                2: be = ae - EW'($urandom_range(0, 9));
                default: be = EW'($urandom);
            endcase
            sw  = be > ae;
            e   = sw ? be : ae;
            bg  = sw ? bs : as_;
            sm  = sw ? as_ : bs;
            gap = sw ? int'(be) - int'(ae) : int'(ae) - int'(be);
            if (gap >= SW) begin
                al = '0;
                st = |sm;
            end else begin
                al = sm >> gap;
                st = |(sm & ((SW'(1) << gap) - SW'(1)));
            end
            drive(ae, as_, be, bs);
            check_all("R3 random", e, bg, al, sw, st);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule